// File: doc/BRIEF.md
# Parity Single-Erasure Corrector

This block sits on the data path of one port of a word-organised memory. On the write side it takes a data word and adds one check bit above it. The check bit is chosen so that the stored word, check bit included, holds an odd number of ones.

On the read side it takes the stored word and an erasure vector, one flag per stored column. A set flag means the storage logic could not deliver that column's bit on this access. The position of the doubtful bit is therefore known in advance. A single check bit is enough to rebuild it: the erased bit is given the value that makes the word's ones count odd again.

When more than one flag is set, the word cannot be rebuilt. The raw bits are passed on and a flag marks the result as unusable. The read outputs can be registered or left combinational.

Top module: `parity_erasure_fixer`

## Requirements
- R1: `wr_word[DW-1:0]` equals `wr_data`, and `wr_word[DW]` is the check bit, set so that the DW+1 bit word has an odd count of ones. This output is combinational.
- R2: With `erase_vec` all zero, `rd_data` equals `rd_word[DW-1:0]` and `rd_bad` is 0.
- R3: With exactly one bit k < DW set in `erase_vec`, `rd_data[k]` takes the value that gives the DW+1 bit word odd parity. All other bits of `rd_data` equal `rd_word`, and `rd_bad` is 0.
- R4: With only bit DW (the check column) set in `erase_vec`, `rd_data` equals `rd_word[DW-1:0]` and `rd_bad` is 0.
- R5: With two or more bits set in `erase_vec`, `rd_data` equals `rd_word[DW-1:0]` unchanged and `rd_bad` is 1.
- R6: With `OUT_REG`=1, `rd_data` and `rd_bad` show the result for the inputs sampled at a rising clock edge, one cycle after those inputs were applied. With `OUT_REG`=0 they are combinational.
- R7: While `rst_n` is low and `OUT_REG`=1, `rd_data` is zero and `rd_bad` is 0.
- R8: The value present on `rd_word` at a single erased position has no effect on `rd_data` or `rd_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | DW | Data word to be written |
| wr_word | output | DW+1 | Word to store: data below, odd-parity check bit at bit DW |
| rd_word | input | DW+1 | Word read from storage, check bit at bit DW |
| erase_vec | input | DW+1 | Per-column erasure flags, bit i covers `rd_word[i]` |
| rd_data | output | DW | Corrected data word |
| rd_bad | output | 1 | More than one erasure flag was set |

## Verification
Each read is built from a correctly encoded word. A chosen set of columns is marked erased, and in some patterns the bit under the erasure is also inverted. The expected data is then simply the original word. An erasure at every data position, with the bit both kept and flipped, shows that the fill value comes from parity and not from the bus. An erasure on the check column separates "ignore the check bit" from "rebuild it". Double and all-column erasures with flipped bits show that raw bits, and not a guessed correction, are passed on together with the error flag.

// File: rtl/parity_erasure_fixer.sv
module parity_erasure_fixer #(
  parameter int DW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  output logic [DW:0]   wr_word,
  input  logic [DW:0]   rd_word,
  input  logic [DW:0]   erase_vec,
  output logic [DW-1:0] rd_data,
  output logic          rd_bad
);
  localparam int SW = DW + 1;

  logic          multi;
  logic          fill;
  logic [DW-1:0] mended;
  logic [DW-1:0] data_c;

  assign wr_word = {~^wr_data, wr_data};

  assign multi = |(erase_vec & (erase_vec - SW'(1)));
  assign fill  = ~^(rd_word & ~erase_vec);

  for (genvar i = 0; i < DW; i++) begin : g_col
    assign mended[i] = erase_vec[i] ? fill : rd_word[i];
  end

  assign data_c = multi ? rd_word[DW-1:0] : mended;

  a_r1_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
    ^wr_word == 1'b1);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_data <= '0;
        rd_bad  <= 1'b0;
      end else begin
        rd_data <= data_c;
        rd_bad  <= multi;
      end
    end

    a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
      erase_vec == '0 |=> rd_data == $past(rd_word[DW-1:0]) && !rd_bad);
    a_r3_single_odd: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(erase_vec) == 1 && !erase_vec[DW])
        |=> !rd_bad && ((^rd_data) ^ $past(rd_word[DW])) == 1'b1);
    a_r4_check_col: assert property (@(posedge clk) disable iff (!rst_n)
      erase_vec == SW'(1) << DW |=> rd_data == $past(rd_word[DW-1:0]) && !rd_bad);
    a_r5_multi_raw: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(erase_vec) > 1 |=> rd_bad && rd_data == $past(rd_word[DW-1:0]));
    a_r5_bad_only_multi: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(erase_vec) |=> !rd_bad);
  end else begin : g_comb
    assign rd_data = data_c;
    assign rd_bad  = multi;
  end
endmodule

// File: tb/parity_erasure_fixer_test.sv
module parity_erasure_fixer_test;
  localparam int DW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW:0]   wr_word;
  logic [DW:0]   rd_word = '0;
  logic [DW:0]   erase_vec = '0;
  logic [DW-1:0] rd_data;
  logic          rd_bad;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] q_data[$];
  logic          q_bad[$];
  string         q_tag[$];

  parity_erasure_fixer #(.DW(DW), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_word(wr_word),
    .rd_word(rd_word), .erase_vec(erase_vec), .rd_data(rd_data), .rd_bad(rd_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // stored = correct odd-parity word of data; flip inverts the erased bits
  task automatic drive(string tag, logic [DW-1:0] data, logic [DW:0] erase, bit flip);
    logic [DW:0] stored, seen;
    int n;
    stored = {~^data, data};
    seen = flip ? (stored ^ erase) : stored;
    n = $countones(erase);
    @(negedge clk);
    wr_data = data;
    rd_word = seen;
    erase_vec = erase;
    q_data.push_back(n > 1 ? seen[DW-1:0] : data);
    q_bad.push_back(n > 1);
    q_tag.push_back(tag);
    #1;
    check("R1 wr_word", 32'(wr_word), 32'(stored));
    check("R1 odd", 32'(^wr_word), 32'd1);
  endtask

  // monitor: result of inputs applied before an edge appears just after it (R6)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_data.size() > 0) begin
        logic [DW-1:0] ed;
        logic eb;
        string t;
        ed = q_data.pop_front();
        eb = q_bad.pop_front();
        t = q_tag.pop_front();
        check({t, " R6 rd_data"}, 32'(rd_data), 32'(ed));
        check({t, " R6 rd_bad"}, 32'(rd_bad), 32'(eb));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rd_word = 9'h1FF;
    erase_vec = 9'h003;
    repeat (3) @(negedge clk);
    check("R7 reset rd_data", 32'(rd_data), 32'd0);
    check("R7 reset rd_bad", 32'(rd_bad), 32'd0);
    rst_n = 1'b1;

    drive("R2 zero", 8'h00, 9'h000, 1'b0);
    drive("R2 ones", 8'hFF, 9'h000, 1'b0);
    drive("R2 mix", 8'hA5, 9'h000, 1'b0);
    drive("R2 odd", 8'h01, 9'h000, 1'b0);
    drive("R3 example", 8'h5E, 9'h004, 1'b1);
    for (int k = 0; k < DW; k++) begin
      drive("R3 keep", 8'h3C ^ 8'(k * 37), 9'(1) << k, 1'b0);
      drive("R8 flip", 8'h3C ^ 8'(k * 37), 9'(1) << k, 1'b1);
    end
    drive("R4 check col", 8'h96, 9'h100, 1'b1);
    drive("R4 check col keep", 8'h7F, 9'h100, 1'b0);
    drive("R5 two", 8'hC3, 9'h011, 1'b1);
    drive("R5 data+check", 8'h12, 9'h180, 1'b1);
    drive("R5 all", 8'h5A, 9'h1FF, 1'b1);
    drive("R2 after multi", 8'h5A, 9'h000, 1'b0);

    while (q_data.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule